// File: doc/BRIEF.md
# Dual-Port Hardware Lock Flag Bank

This block holds eight hardware lock flags that two independent ports, left and right, share. A port claims a flag by writing a request to it and gives the flag up by writing a release. Either port can read back the state of a flag as seen from its own side. At most one side owns a flag at a time. A request from the side that does not own the flag waits as a pending request, and it becomes ownership by itself as soon as the owner releases. When both sides request a free flag in the same cycle, a one-bit alternating tie-breaker decides the winner, so the outcome is repeatable.

A port reaches the flags only while its memory enable is low and its lock select is high. The block has a single clock and synchronous strobes. Software uses it to guard shared resources: request a flag, read it back, and go ahead only when the read shows the flag as granted.

Top module: `dual_lock_bank`

## Requirements
- R1: Address bits [2:0] choose one of eight flags. An access to one flag never changes the state of any other flag.
- R2: A port's read or write acts only in a cycle where its lock select is 1 and its memory enable is 0. In any other cycle the strobes change neither the flags nor that port's read data.
- R3: A write with data bit 0 equal to 0 requests the addressed flag. A write with data bit 0 equal to 1 releases it. Data bits [7:1] have no effect.
- R4: A read returns 8'h00 when the reading port owns the flag and 8'hFF in every other case, so a free flag reads as all ones from both ports.
- R5: A flag has at most one owner. A request made while the opposite side owns the flag stays pending, and it is granted in the same cycle that the owner's release is written.
- R6: When both ports request the same free flag in one cycle, exactly one of them wins. The left port wins the first such tie after reset, and the winner alternates on every later tie.
- R7: A release from a port that does not own the flag leaves the owner's ownership unchanged. It clears only that port's own pending request.
- R8: Read data is registered. It is updated at the clock edge that samples a valid read strobe and holds its value otherwise. A read has no side effects. A read in the cycle after a write from the same side returns the updated value.
- R9: A synchronous active-high reset releases all flags, clears all pending requests, restores the left-first tie order and sets both read data buses to 8'hFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lMemEn | input | 1 | Left memory enable; must be 0 for a flag access |
| lLockSel | input | 1 | Left lock select |
| lWrEn | input | 1 | Left write strobe |
| lRdEn | input | 1 | Left read strobe |
| lAddr | input | 3 | Left flag address |
| lWrData | input | 8 | Left write data (bit 0 used) |
| lRdData | output | 8 | Left registered read data |
| rMemEn | input | 1 | Right memory enable; must be 0 for a flag access |
| rLockSel | input | 1 | Right lock select |
| rWrEn | input | 1 | Right write strobe |
| rRdEn | input | 1 | Right read strobe |
| rAddr | input | 3 | Right flag address |
| rWrData | input | 8 | Right write data (bit 0 used) |
| rRdData | output | 8 | Right registered read data |

## Verification
A write takes effect at the clock edge that samples it. A read issued in the following cycle is captured at its own edge and is visible on the read bus directly after that edge. The bench drives every strobe on the falling edge, removes it on the next falling edge, and compares the read bus at that falling edge, which is half a period after the capturing edge. Pending grants and tie outcomes are therefore checked one read cycle after the write that causes them, and the held value of a read bus is checked after cycles that carry no valid read.

// File: rtl/dual_lock_pkg.sv
package dual_lock_pkg;
  localparam int NUM_FLAGS = 8;
  localparam int ADDR_W    = $clog2(NUM_FLAGS);
  localparam int DATA_W    = 8;

  typedef struct packed {
    logic [NUM_FLAGS-1:0] setReq;
    logic [NUM_FLAGS-1:0] clrReq;
    logic                 rdStb;
    logic [ADDR_W-1:0]    rdAddr;
  } portStrobe_t;

  typedef struct packed {
    portStrobe_t left;
    portStrobe_t right;
  } lockStrobes_t;
endpackage

// File: rtl/dual_lock_ctrl.sv
module dual_lock_ctrl
  import dual_lock_pkg::*;
(
  input  logic              lMemEn,
  input  logic              lLockSel,
  input  logic              lWrEn,
  input  logic              lRdEn,
  input  logic [ADDR_W-1:0] lAddr,
  input  logic              lWrBit,
  input  logic              rMemEn,
  input  logic              rLockSel,
  input  logic              rWrEn,
  input  logic              rRdEn,
  input  logic [ADDR_W-1:0] rAddr,
  input  logic              rWrBit,
  output lockStrobes_t      strobes
);
  logic lAcc, rAcc;
  assign lAcc = lLockSel & ~lMemEn;
  assign rAcc = rLockSel & ~rMemEn;

  for (genvar f = 0; f < NUM_FLAGS; f++) begin : g_dec
    logic lHit, rHit;
    assign lHit = lAcc & lWrEn & (lAddr == ADDR_W'(f));
    assign rHit = rAcc & rWrEn & (rAddr == ADDR_W'(f));
    assign strobes.left.setReq[f]  = lHit & ~lWrBit;
    assign strobes.left.clrReq[f]  = lHit &  lWrBit;
    assign strobes.right.setReq[f] = rHit & ~rWrBit;
    assign strobes.right.clrReq[f] = rHit &  rWrBit;
  end

  assign strobes.left.rdStb   = lAcc & lRdEn;
  assign strobes.left.rdAddr  = lAddr;
  assign strobes.right.rdStb  = rAcc & rRdEn;
  assign strobes.right.rdAddr = rAddr;
endmodule

// File: rtl/dual_lock_dp.sv
module dual_lock_dp
  import dual_lock_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  lockStrobes_t         strobes,
  output logic [NUM_FLAGS-1:0] ownL,
  output logic [NUM_FLAGS-1:0] ownR,
  output logic [DATA_W-1:0]    lRdData,
  output logic [DATA_W-1:0]    rRdData
);
  logic [NUM_FLAGS-1:0] reqL, reqR;
  logic [NUM_FLAGS-1:0] nextReqL, nextReqR, nextOwnL, nextOwnR, tieHit;
  logic                 tieLeft;

  for (genvar f = 0; f < NUM_FLAGS; f++) begin : g_flag
    logic keepL, keepR;
    always_comb begin
      nextReqL[f] = strobes.left.clrReq[f]  ? 1'b0 : (strobes.left.setReq[f]  | reqL[f]);
      nextReqR[f] = strobes.right.clrReq[f] ? 1'b0 : (strobes.right.setReq[f] | reqR[f]);
      keepL = ownL[f] & nextReqL[f];
      keepR = ownR[f] & nextReqR[f];
      tieHit[f]   = ~keepL & ~keepR & nextReqL[f] & nextReqR[f];
      nextOwnL[f] = keepL | (~keepR & nextReqL[f] & (~nextReqR[f] | tieLeft));
      nextOwnR[f] = keepR | (~keepL & nextReqR[f] & (~nextReqL[f] | ~tieLeft));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reqL    <= '0;
      reqR    <= '0;
      ownL    <= '0;
      ownR    <= '0;
      tieLeft <= 1'b1;
    end else begin
      reqL <= nextReqL;
      reqR <= nextReqR;
      ownL <= nextOwnL;
      ownR <= nextOwnR;
      if (|tieHit) tieLeft <= ~tieLeft;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lRdData <= '1;
      rRdData <= '1;
    end else begin
      if (strobes.left.rdStb)  lRdData <= {DATA_W{~ownL[strobes.left.rdAddr]}};
      if (strobes.right.rdStb) rRdData <= {DATA_W{~ownR[strobes.right.rdAddr]}};
    end
  end
endmodule

// File: rtl/dual_lock_bank.sv
module dual_lock_bank
  import dual_lock_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              lMemEn,
  input  logic              lLockSel,
  input  logic              lWrEn,
  input  logic              lRdEn,
  input  logic [ADDR_W-1:0] lAddr,
  input  logic [DATA_W-1:0] lWrData,
  output logic [DATA_W-1:0] lRdData,
  input  logic              rMemEn,
  input  logic              rLockSel,
  input  logic              rWrEn,
  input  logic              rRdEn,
  input  logic [ADDR_W-1:0] rAddr,
  input  logic [DATA_W-1:0] rWrData,
  output logic [DATA_W-1:0] rRdData
);
  lockStrobes_t         strobes;
  logic [NUM_FLAGS-1:0] ownL, ownR;

  dual_lock_ctrl ctrl_i (
    .lMemEn(lMemEn), .lLockSel(lLockSel), .lWrEn(lWrEn), .lRdEn(lRdEn),
    .lAddr(lAddr), .lWrBit(lWrData[0]),
    .rMemEn(rMemEn), .rLockSel(rLockSel), .rWrEn(rWrEn), .rRdEn(rRdEn),
    .rAddr(rAddr), .rWrBit(rWrData[0]),
    .strobes(strobes)
  );

  dual_lock_dp dp_i (
    .clk(clk), .rst(rst), .strobes(strobes),
    .ownL(ownL), .ownR(ownR),
    .lRdData(lRdData), .rRdData(rRdData)
  );
endmodule

// File: rtl/dual_lock_chk.sv
module dual_lock_chk
  import dual_lock_pkg::*;
(
  input logic                 clk,
  input logic                 rst,
  input logic                 lMemEn,
  input logic                 lLockSel,
  input logic                 lWrEn,
  input logic                 lRdEn,
  input logic [ADDR_W-1:0]    lAddr,
  input logic [DATA_W-1:0]    lRdData,
  input logic                 rMemEn,
  input logic                 rLockSel,
  input logic                 rWrEn,
  input logic                 rRdEn,
  input logic [ADDR_W-1:0]    rAddr,
  input logic [DATA_W-1:0]    rRdData,
  input logic [NUM_FLAGS-1:0] ownL,
  input logic [NUM_FLAGS-1:0] ownR
);
  logic pastValid = 1'b0;
  always_ff @(posedge clk) pastValid <= 1'b1;

  logic lRd, rRd, lWr, rWr;
  assign lRd = lLockSel & ~lMemEn & lRdEn;
  assign rRd = rLockSel & ~rMemEn & rRdEn;
  assign lWr = lLockSel & ~lMemEn & lWrEn;
  assign rWr = rLockSel & ~rMemEn & rWrEn;

  // R5: never two owners of one flag
  p_single_owner_r5: assert property (@(posedge clk) disable iff (rst)
    pastValid |-> ((ownL & ownR) == '0));

  // R4: read bus is all zeros or all ones
  p_all_bits_r4: assert property (@(posedge clk) disable iff (rst)
    pastValid |-> ((lRdData == '0 || lRdData == '1) && (rRdData == '0 || rRdData == '1)));

  // R8: a valid read lands one edge later with the reading side's view
  p_read_latency_r8: assert property (@(posedge clk) disable iff (rst)
    (pastValid && lRd) |=> (lRdData == {DATA_W{~$past(ownL[lAddr])}}));

  // R8: no valid read, read bus holds
  p_read_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (pastValid && !rRd) |=> $stable(rRdData));

  // R2: without any valid write, ownership does not move
  p_gate_r2: assert property (@(posedge clk) disable iff (rst)
    (pastValid && !lWr && !rWr) |=> ($stable(ownL) && $stable(ownR)));

  // R7: the left side never loses a flag without its own write
  p_no_steal_r7: assert property (@(posedge clk) disable iff (rst)
    (pastValid && !lWr) |=> ((ownL & $past(ownL)) == $past(ownL)));

  // R9: after a reset edge everything is released
  p_reset_r9: assert property (@(posedge clk)
    (pastValid && $past(rst)) |-> (ownL == '0 && ownR == '0 && lRdData == '1 && rRdData == '1));
endmodule

bind dual_lock_bank dual_lock_chk chk_i (
  .clk(clk), .rst(rst),
  .lMemEn(lMemEn), .lLockSel(lLockSel), .lWrEn(lWrEn), .lRdEn(lRdEn),
  .lAddr(lAddr), .lRdData(lRdData),
  .rMemEn(rMemEn), .rLockSel(rLockSel), .rWrEn(rWrEn), .rRdEn(rRdEn),
  .rAddr(rAddr), .rRdData(rRdData),
  .ownL(ownL), .ownR(ownR)
);

// File: tb/dual_lock_bank_tb_top.sv
module dual_lock_bank_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic lMemEn = 0, lLockSel = 0, lWrEn = 0, lRdEn = 0;
  logic rMemEn = 0, rLockSel = 0, rWrEn = 0, rRdEn = 0;
  logic [2:0] lAddr = 0, rAddr = 0;
  logic [7:0] lWrData = 0, rWrData = 0;
  logic [7:0] lRdData, rRdData;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  bit mReqL[8], mReqR[8], mOwnL[8], mOwnR[8];
  bit mTieLeft;

  always #2 clk = ~clk;

  dual_lock_bank dut_i (
    .clk(clk), .rst(rst),
    .lMemEn(lMemEn), .lLockSel(lLockSel), .lWrEn(lWrEn), .lRdEn(lRdEn),
    .lAddr(lAddr), .lWrData(lWrData), .lRdData(lRdData),
    .rMemEn(rMemEn), .rLockSel(rLockSel), .rWrEn(rWrEn), .rRdEn(rRdEn),
    .rAddr(rAddr), .rWrData(rWrData), .rRdData(rRdData)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic modelReset();
    for (int f = 0; f < 8; f++) begin
      mReqL[f] = 0; mReqR[f] = 0; mOwnL[f] = 0; mOwnR[f] = 0;
    end
    mTieLeft = 1;
  endtask

  task automatic modelStep(input bit lv, input bit [2:0] la, input bit ld,
                           input bit rv, input bit [2:0] ra, input bit rd);
    for (int f = 0; f < 8; f++) begin
      bit nl, nr;
      nl = (lv && la == f) ? !ld : mReqL[f];
      nr = (rv && ra == f) ? !rd : mReqR[f];
      if (mOwnL[f] && nl) begin
        mOwnR[f] = 0;
      end else if (mOwnR[f] && nr) begin
        mOwnL[f] = 0;
      end else if (nl && nr) begin
        mOwnL[f] = mTieLeft; mOwnR[f] = !mTieLeft; mTieLeft = !mTieLeft;
      end else begin
        mOwnL[f] = nl; mOwnR[f] = nr;
      end
      mReqL[f] = nl; mReqR[f] = nr;
    end
  endtask

  task automatic doReset();
    @(negedge clk); rst = 1;
    @(negedge clk); @(negedge clk); rst = 0;
    modelReset();
  endtask

  // one cycle of writes; lv/rv request a write, lm/rm raise memory enable
  task automatic writeOp(input bit lv, input bit [2:0] la, input bit [7:0] ld, input bit lm,
                         input bit rv, input bit [2:0] ra, input bit [7:0] rd, input bit rm);
    @(negedge clk);
    lLockSel = lv; lWrEn = lv; lAddr = la; lWrData = ld; lMemEn = lm;
    rLockSel = rv; rWrEn = rv; rAddr = ra; rWrData = rd; rMemEn = rm;
    @(negedge clk);
    lLockSel = 0; lWrEn = 0; lMemEn = 0; rLockSel = 0; rWrEn = 0; rMemEn = 0;
    modelStep(lv && !lm, la, ld[0], rv && !rm, ra, rd[0]);
  endtask

  task automatic readOp(input bit [2:0] la, input bit [2:0] ra,
                        output logic [7:0] lv, output logic [7:0] rv);
    @(negedge clk);
    lLockSel = 1; lRdEn = 1; lAddr = la; rLockSel = 1; rRdEn = 1; rAddr = ra;
    @(negedge clk);
    lLockSel = 0; lRdEn = 0; rLockSel = 0; rRdEn = 0;
    lv = lRdData; rv = rRdData;
  endtask

  function automatic logic [7:0] expL(input int f); return mOwnL[f] ? 8'h00 : 8'hFF; endfunction
  function automatic logic [7:0] expR(input int f); return mOwnR[f] ? 8'h00 : 8'hFF; endfunction

  initial begin
    #(4 * 190000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] a, b;
    logic [15:0] lfsr;
    doReset();

    // R9: reset state, every flag free from both sides
    for (int f = 0; f < 8; f++) begin
      readOp(3'(f), 3'(f), a, b);
      check("R9 reset left", a, 8'hFF);
      check("R9 reset right", b, 8'hFF);
    end

    // R3/R4: left requests flag 2 with upper data bits set
    writeOp(1, 2, 8'hFE, 0, 0, 0, 0, 0);
    readOp(2, 2, a, b);
    check("R3 upper bits ignored, left owns", a, 8'h00);
    check("R4 other side sees taken", b, 8'hFF);

    // R5: right request pends, then granted on left release
    writeOp(0, 0, 0, 0, 1, 2, 8'h00, 0);
    readOp(2, 2, a, b);
    check("R5 left keeps", a, 8'h00);
    check("R5 right pending", b, 8'hFF);
    writeOp(1, 2, 8'h01, 0, 0, 0, 0, 0);
    readOp(2, 2, a, b);
    check("R5 left released", a, 8'hFF);
    check("R5 right granted", b, 8'h00);

    // R7: left requests then releases while not owning
    writeOp(1, 2, 8'h00, 0, 0, 0, 0, 0);
    writeOp(1, 2, 8'hFF, 0, 0, 0, 0, 0);
    readOp(2, 2, a, b);
    check("R7 owner unaffected", b, 8'h00);
    writeOp(0, 0, 0, 0, 1, 2, 8'h01, 0);
    readOp(2, 2, a, b);
    check("R7 left pending cleared", a, 8'hFF);
    check("R7 flag free", b, 8'hFF);

    // R6: ties alternate, left first
    writeOp(1, 5, 8'h00, 0, 1, 5, 8'h00, 0);
    readOp(5, 5, a, b);
    check("R6 first tie left", a, 8'h00);
    check("R6 first tie right refused", b, 8'hFF);
    writeOp(1, 5, 8'h01, 0, 1, 5, 8'h01, 0);
    writeOp(1, 5, 8'h00, 0, 1, 5, 8'h00, 0);
    readOp(5, 5, a, b);
    check("R6 second tie left refused", a, 8'hFF);
    check("R6 second tie right", b, 8'h00);
    writeOp(1, 5, 8'h01, 0, 1, 5, 8'h01, 0);

    // R2: memory enable high or select low blocks access
    writeOp(1, 3, 8'h00, 1, 1, 3, 8'h00, 1);
    readOp(3, 3, a, b);
    check("R2 gated write left", a, 8'hFF);
    check("R2 gated write right", b, 8'hFF);
    writeOp(1, 3, 8'h00, 0, 0, 0, 0, 0);
    readOp(3, 3, a, b);
    @(negedge clk);
    lLockSel = 1; lRdEn = 1; lMemEn = 1; lAddr = 0;
    rLockSel = 0; rRdEn = 1; rAddr = 3;
    @(negedge clk);
    lLockSel = 0; lRdEn = 0; lMemEn = 0; rRdEn = 0;
    check("R2 gated read left holds", lRdData, 8'h00);
    check("R2 gated read right holds", rRdData, 8'hFF);

    // R8: output holds without read, updates on the next read
    writeOp(1, 3, 8'h01, 0, 0, 0, 0, 0);
    check("R8 hold after write", lRdData, 8'h00);
    readOp(3, 3, a, b);
    check("R8 read after write", a, 8'hFF);

    // R1: each flag alone, all others stay free
    for (int f = 0; f < 8; f++) begin
      writeOp(1, 3'(f), 8'h00, 0, 0, 0, 0, 0);
      for (int g = 0; g < 8; g++) begin
        readOp(3'(g), 3'(g), a, b);
        check("R1 left view", a, (g == f) ? 8'h00 : 8'hFF);
        check("R1 right view", b, 8'hFF);
      end
      writeOp(1, 3'(f), 8'h01, 0, 0, 0, 0, 0);
    end

    // R5 R6 R7: pseudo-random traffic against the model
    lfsr = 16'hACE1;
    for (int i = 0; i < 3000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      writeOp(lfsr[0], {1'b0, lfsr[2:1]}, {7'h55, lfsr[3]}, lfsr[9] & lfsr[10],
              lfsr[4], {1'b0, lfsr[6:5]}, {7'h2A, lfsr[7]}, lfsr[11] & lfsr[12]);
      readOp({1'b0, lfsr[14:13]}, {1'b0, lfsr[15], lfsr[8]}, a, b);
      check("R5 random left", a, expL({1'b0, lfsr[14:13]}));
      check("R6 random right", b, expR({1'b0, lfsr[15], lfsr[8]}));
    end

    // R9: reset mid-run restores left-first ties
    writeOp(1, 6, 8'h00, 0, 0, 0, 0, 0);
    doReset();
    readOp(6, 6, a, b);
    check("R9 mid-run reset", a, 8'hFF);
    writeOp(1, 7, 8'h00, 0, 1, 7, 8'h00, 0);
    readOp(7, 7, a, b);
    check("R9 tie order restored", a, 8'h00);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule